// File: doc/BRIEF.md
# Host Bus Slave Port with Transfer Acknowledge

This block is the device side of a 16-bit asynchronous host bus in the style of a 68000-family processor. The host opens a cycle by pulling an active-low chip select. It qualifies the cycle with an upper-byte write strobe, a lower-byte write strobe or an output enable, and it presents a word address. The port brings all of these strobes into the bus clock domain. It then counts a fixed number of bus clocks and ends the cycle with an active-low transfer acknowledge. While the host is waiting, the port sequences the acknowledge line through three steps: released, driven high, then driven low. When chip select is removed, the port drives the line high for one clock and then releases it again.

The cycle length depends on the ratio between the internal memory clock and the bus clock. A 2-bit input picks that ratio, and the length it gives is not linear in the ratio. A write is handed to the memory side as a one-clock request carrying the word address, the data and the byte lanes. A read presents the latched address to the memory side, registers the returned word and drives it onto the data bus until the cycle ends. The tri-state nature of the pads is shown by an output-enable signal next to each output: one for the data bus and one for the acknowledge line.

Top module: `host_bus_port`

## Requirements
- R1: While reset is asserted and on the first clocks after it, ack_oe=0, ack_n=1, data_oe=0 and wr_valid=0.
- R2: Let edge 0 be the first rising clock edge that samples cs_n low. From edge 2 the port drives the acknowledge line (ack_oe=1) with the value high (ack_n=1).
- R3: ack_n goes low at edge L-1, where L is 8, 11, 13 or 17 for div_sel 0, 1, 2 or 3. The port takes div_sel once, at edge 2. A later change of div_sel during the cycle has no effect on that cycle.
- R4: Let edge r be the first edge that samples cs_n high after an acknowledged cycle. ack_n stays low through edge r+1, and at edge r+2 it is driven high with ack_oe=1. At edge r+3 ack_oe=0.
- R5: In a write cycle (wr_hi_n or wr_lo_n low together with cs_n), wr_valid is high for exactly the one clock that begins at edge L-1. During that clock wr_addr and wr_data hold the addr and data_in values sampled at edge 2, wr_be[1] is set for an upper-byte strobe and wr_be[0] for a lower-byte strobe.
- R6: In a read cycle (oe_n low, both write strobes high), data_oe=1 from edge 2 until edge r+2, when it falls. rd_addr holds the address sampled at edge 2. data_out at edge L-1 equals the rd_data that the memory side returns for that address.
- R7: A write cycle never drives the data bus (data_oe stays 0).
- R8: If cs_n is first sampled high at edge r with r <= L-3, the cycle is aborted. ack_n never goes low, wr_valid never pulses, ack_oe is still driven high through edge r+2 and is released at edge r+3.
- R9: A cycle with neither a write strobe nor the output enable is still acknowledged after L-1 edges. It issues no write and does not drive the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| div_sel | input | 2 | Memory clock ratio: 0=/1, 1=/2, 2=/3, 3=/4 |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_hi_n | input | 1 | Upper-byte write strobe, active low |
| wr_lo_n | input | 1 | Lower-byte write strobe, active low |
| oe_n | input | 1 | Read output enable, active low |
| addr | input | 16 | Word address from host |
| data_in | input | 16 | Data bus as seen from the pad input |
| data_out | output | 16 | Read data driven towards the pad |
| data_oe | output | 1 | Data pad output enable |
| ack_n | output | 1 | Transfer acknowledge value, active low |
| ack_oe | output | 1 | Acknowledge pad output enable |
| rd_addr | output | 16 | Latched address to memory for reads |
| rd_data | input | 16 | Memory read word for rd_addr |
| wr_valid | output | 1 | One-clock write request |
| wr_addr | output | 16 | Write word address |
| wr_data | output | 16 | Write data |
| wr_be | output | 2 | Byte lanes: bit 1 upper, bit 0 lower |

## Verification
The assertions assume that the host asserts its qualifying strobe in the same clock period as chip select and removes it with chip select. They assume that address and write data stay steady through the third sampling edge, and that rd_data follows rd_addr without delay. They also assume that chip select stays high long enough for the release sequence to finish before the next cycle. The stimulus changes cs_n and the strobes together on falling clock edges, and it leaves a gap after each cycle that covers the whole release. Address, data and div_sel change only after the port has captured them, and those changes are made on purpose to show that later values have no effect.

// File: rtl/host_bus_port.sv
module host_bus_port #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int LEN0 = 8,
  parameter int LEN1 = 11,
  parameter int LEN2 = 13,
  parameter int LEN3 = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    div_sel,
  input  logic          cs_n,
  input  logic          wr_hi_n,
  input  logic          wr_lo_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          ack_n,
  output logic          ack_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [1:0]    wr_be
);
  localparam int CW = $clog2(LEN3);
  localparam int LAT = 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ACK, S_REL} st_t;

  st_t st;
  logic [3:0] s1, s2;
  logic cs_s, wh_s, wl_s, oe_s;
  logic [CW-1:0] cnt, load;
  logic is_wr, is_rd;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= ~{cs_n, wr_hi_n, wr_lo_n, oe_n};
      s2 <= s1;
    end

  assign {cs_s, wh_s, wl_s, oe_s} = s2;

  always_comb
    case (div_sel)
      2'd0:    load = CW'(LEN0 - LAT - 1);
      2'd1:    load = CW'(LEN1 - LAT - 1);
      2'd2:    load = CW'(LEN2 - LAT - 1);
      default: load = CW'(LEN3 - LAT - 1);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      is_wr    <= 1'b0;
      is_rd    <= 1'b0;
      addr_q   <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
      wr_valid <= 1'b0;
      data_out <= '0;
    end else begin
      wr_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (cs_s) begin
            st      <= S_RUN;
            cnt     <= load;
            addr_q  <= addr;
            wr_data <= data_in;
            wr_be   <= {wh_s, wl_s};
            is_wr   <= wh_s | wl_s;
            is_rd   <= oe_s & ~(wh_s | wl_s);
          end
        S_RUN: begin
          data_out <= rd_data;
          if (!cs_s)
            st <= S_REL;
          else if (cnt == '0) begin
            st       <= S_ACK;
            wr_valid <= is_wr;
          end else
            cnt <= cnt - 1'b1;
        end
        S_ACK:
          if (!cs_s) st <= S_REL;
        default:
          st <= S_IDLE;
      endcase
    end

  assign ack_oe  = (st != S_IDLE);
  assign ack_n   = (st != S_ACK);
  assign data_oe = is_rd && (st == S_RUN || st == S_ACK);
  assign rd_addr = addr_q;
  assign wr_addr = addr_q;

  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r5_wr_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $fell(ack_n));
  a_r4_high_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe) |-> $past(ack_n));
  a_r3_ack_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(ack_oe));
  a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && $past(!ack_n)) |-> $stable(data_out));
  a_r6_drive_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> (ack_n && ack_oe));
  a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !data_oe);
endmodule

// File: tb/host_bus_port_tb.sv
module host_bus_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic cs_n = 1'b1, wr_hi_n = 1'b1, wr_lo_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0, data_in = '0, rd_data;
  logic [15:0] data_out, rd_addr, wr_addr, wr_data;
  logic data_oe, ack_n, ack_oe, wr_valid;
  logic [1:0] wr_be;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;
  assign rd_data = rd_addr ^ 16'hA5C3;

  host_bus_port u_dut (.*);

  function automatic int cyc_len(input logic [1:0] d);
    case (d)
      2'd0: return 8;
      2'd1: return 11;
      2'd2: return 13;
      default: return 17;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 write, 1 read, 2 no qualifier
  task automatic run_cycle(input int kind, input logic [1:0] be, input logic [1:0] dv,
                           input int rel, input bit chg_div);
    int L = cyc_len(dv);
    bit acked = (rel >= L - 3);
    logic [15:0] a = 16'($urandom), d = 16'($urandom);
    addr = a; data_in = d; div_sel = dv;
    wr_hi_n = !(kind == 0 && be[1]);
    wr_lo_n = !(kind == 0 && be[0]);
    oe_n = (kind != 1);
    cs_n = 1'b0;
    for (int n = 0; n <= rel + 5; n++) begin
      @(posedge clk); @(negedge clk);
      check((n > rel) ? (acked ? "R4" : "R8") : "R2", "ack_oe", ack_oe, (n >= 2 && n <= rel + 3));
      check(acked ? ((n > rel) ? "R4" : "R3") : "R8", "ack_n", ack_n,
            !(acked && n >= L - 1 && n < rel + 3));
      check(kind == 0 ? (acked ? "R5" : "R8") : "R9", "wr_valid", wr_valid,
            (kind == 0 && acked && n == L - 1));
      check(kind == 1 ? "R6" : (kind == 0 ? "R7" : "R9"), "data_oe", data_oe,
            (kind == 1 && n >= 2 && n <= rel + 2));
      if (wr_valid) begin
        check("R5", "wr_addr", wr_addr, a);
        check("R5", "wr_data", wr_data, d);
        check("R5", "wr_be", wr_be, be);
      end
      if (kind == 1 && acked && n == L - 1) begin
        check("R6", "rd_addr", rd_addr, a);
        check("R6", "data_out", data_out, a ^ 16'hA5C3);
      end
      if (n == 2) begin
        addr = 16'($urandom);
        data_in = 16'($urandom);
      end
      if (n == 3 && chg_div) div_sel = ~dv;
      if (n == rel) begin
        cs_n = 1'b1; wr_hi_n = 1'b1; wr_lo_n = 1'b1; oe_n = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", "ack_oe in reset", ack_oe, 0);
    check("R1", "ack_n in reset", ack_n, 1);
    check("R1", "data_oe in reset", data_oe, 0);
    check("R1", "wr_valid in reset", wr_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "ack_oe after reset", ack_oe, 0);
    check("R1", "wr_valid after reset", wr_valid, 0);
    for (int dv = 0; dv < 4; dv++) begin
      run_cycle(0, 2'b11, 2'(dv), cyc_len(2'(dv)) - 1, 1'b0);
      run_cycle(1, 2'b00, 2'(dv), cyc_len(2'(dv)) + 1, 1'b0);
    end
    run_cycle(0, 2'b10, 2'd1, 12, 1'b0);
    run_cycle(0, 2'b01, 2'd2, 14, 1'b0);
    run_cycle(0, 2'b11, 2'd0, 0, 1'b0);
    run_cycle(1, 2'b00, 2'd3, 13, 1'b0);
    run_cycle(0, 2'b11, 2'd3, 14, 1'b0);
    run_cycle(0, 2'b01, 2'd0, 5, 1'b0);
    run_cycle(2, 2'b00, 2'd1, 11, 1'b0);
    run_cycle(0, 2'b11, 2'd0, 9, 1'b1);
    run_cycle(1, 2'b00, 2'd3, 18, 1'b1);
    for (int i = 0; i < 40; i++) begin
      int k = $urandom_range(0, 2);
      logic [1:0] dv = 2'($urandom_range(0, 3));
      logic [1:0] be = 2'($urandom_range(1, 3));
      run_cycle(k, be, dv, $urandom_range(0, cyc_len(dv) + 3), 1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule